// File: doc/BRIEF.md
# Bus Target Selection Responder

This block sits on the target side of a parallel peripheral bus. It watches for an initiator that is trying to select this device. A selection attempt counts only when the select line and the device's own ID bit on the data lines are both true, and busy and the direction line are both false. The same input pattern must also stay unchanged for a settle interval. The block rejects the attempt if the data byte fails odd parity, or if more than two ID bits are set.

When a selection is accepted, the block re-checks the bus one cycle later. If the selection is still valid, it drives busy to claim the bus and latches the initiator's ID. It then waits for the initiator to drop select, raises the request line to open the first information transfer phase, and sends a one-cycle pulse to the transfer logic. A bus reset forces both bus drives low in the same cycle and returns the block to idle. All bus delays are counted in clock cycles and set by parameters.

Top module: `sel_responder`

## Requirements
- R1: After reset is released, busy drive, request drive, selected pulse, initiator ID and ID valid are all 0.
- R2: A selection qualifies when `bus_sel`=1, `bus_data[own_id]`=1, `bus_bsy`=0 and `bus_io`=0. Once the inputs qualify and stay unchanged, `bsy_drv` rises after exactly SETTLE_CYC+2 rising edges, counted from the first edge that samples them. It is still 0 after SETTLE_CYC+1 edges.
- R3: Parity is odd over `{bus_data, bus_par}`. A byte that fails it gets no response. An all-zero byte with `bus_par`=0 counts as bad parity.
- R4: A byte with more than two bits set gets no response, even when its parity is good.
- R5: If `bus_bsy` or `bus_io` is 1, or the own ID bit is 0, there is no response.
- R6: Any change on `bus_sel`, `bus_bsy`, `bus_io`, `bus_par` or `bus_data` during the settle window restarts the count. The inputs then need the full interval again.
- R7: In the cycle after detection, the block checks the bus again. If the selection no longer qualifies, busy is never driven and the block goes back to idle.
- R8: Busy is driven no later than ABORT_CYC cycles after detection.
- R9: While `bus_sel` stays 1 after the claim, `req_drv` stays 0. The edge that samples `bus_sel`=0 raises `req_drv`, which then stays high, and `selected` is high for that one cycle only.
- R10: `init_id` is the index of the highest set data bit other than `own_id`. It is latched at the claim. `init_id_ok` is 0 when no other bit is set.
- R11: When `bus_rst`=1, `bsy_drv`, `req_drv` and `selected` drop in the same cycle, and the block is idle on the next edge. This holds even if SEL is released in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Select line level |
| bus_bsy | input | 1 | Busy line level |
| bus_io | input | 1 | Direction line level |
| bus_rst | input | 1 | Bus reset line level |
| bus_data | input | 8 | Data lines carrying ID bits |
| bus_par | input | 1 | Data parity line |
| own_id | input | 3 | Configured ID of this device |
| bsy_drv | output | 1 | Drive busy |
| req_drv | output | 1 | Drive request |
| init_id | output | 3 | Captured initiator ID |
| init_id_ok | output | 1 | Initiator ID is valid |
| selected | output | 1 | One-cycle pulse when transfer phase opens |

## Verification
A bus reset and the initiator's release of SEL can land on the same edge. That edge would otherwise open the transfer phase. The bench claims the bus, then drives SEL low and the bus reset high at the same falling edge. It expects `req_drv` and `selected` to stay 0 on that edge and after the reset is released, so the reset must win. A second pairing is a change to the data byte on the same edge that the settle counter would have finished. This is judged by where `bsy_drv` rises relative to the change.

// File: rtl/sel_responder.sv
module sel_responder #(
  parameter int SETTLE_CYC = 4,
  parameter int ABORT_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_bsy,
  input  logic       bus_io,
  input  logic       bus_rst,
  input  logic [7:0] bus_data,
  input  logic       bus_par,
  input  logic [2:0] own_id,
  output logic       bsy_drv,
  output logic       req_drv,
  output logic [2:0] init_id,
  output logic       init_id_ok,
  output logic       selected
);
  localparam int CW = $clog2(SETTLE_CYC + 1) + 1;
  localparam int AW = $clog2(ABORT_CYC + 1) + 1;

  typedef enum logic [2:0] {IDLE, SETTLE, CONFIRM, CLAIM, XFER} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [11:0]   snap;
  logic [11:0]   cur;
  logic [3:0]    ones;
  logic          par_ok, qual, pulse;
  logic [2:0]    id_c;
  logic          vld_c;

  assign cur    = {bus_sel, bus_bsy, bus_io, bus_par, bus_data};
  assign ones   = 4'($countones(bus_data));
  assign par_ok = ^{bus_data, bus_par};
  assign qual   = bus_sel & bus_data[own_id] & ~bus_bsy & ~bus_io & par_ok & (ones <= 4'd2);

  always_comb begin
    id_c  = '0;
    vld_c = 1'b0;
    for (int i = 0; i < 8; i++)
      if (bus_data[i] && (3'(i) != own_id)) begin
        id_c  = 3'(i);
        vld_c = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      snap       <= '0;
      pulse      <= 1'b0;
      init_id    <= '0;
      init_id_ok <= 1'b0;
    end else if (bus_rst) begin
      st         <= IDLE;
      cnt        <= '0;
      pulse      <= 1'b0;
      init_id    <= '0;
      init_id_ok <= 1'b0;
    end else begin
      pulse <= 1'b0;
      case (st)
        IDLE:
          if (qual) begin
            st   <= SETTLE;
            snap <= cur;
            cnt  <= CW'(1);
          end
        SETTLE:
          if (!qual) st <= IDLE;
          else if (cur != snap) begin
            snap <= cur;
            cnt  <= CW'(1);
          end else if (cnt >= CW'(SETTLE_CYC)) st <= CONFIRM;
          else cnt <= cnt + 1'b1;
        CONFIRM:
          if (qual) begin
            st         <= CLAIM;
            init_id    <= id_c;
            init_id_ok <= vld_c;
          end else st <= IDLE;
        CLAIM:
          if (!bus_sel) begin
            st    <= XFER;
            pulse <= 1'b1;
          end
        XFER: ;
        default: st <= IDLE;
      endcase
    end

  assign bsy_drv  = ((st == CLAIM) || (st == XFER)) & ~bus_rst;
  assign req_drv  = (st == XFER) & ~bus_rst;
  assign selected = pulse & ~bus_rst;

  logic [AW-1:0] ab_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ab_cnt <= '0;
    else if (st == CONFIRM) ab_cnt <= ab_cnt + 1'b1;
    else ab_cnt <= '0;

  assert_abort_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cnt < AW'(ABORT_CYC));

  assert_claim_recheck_R7: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (st == CONFIRM && !qual) |=> !bsy_drv);

  assert_bad_parity_R3: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (st == IDLE && !par_ok) |=> !bsy_drv && st == IDLE);

  assert_req_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    $rose(req_drv) |-> $past(!bus_sel));

  assert_req_with_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_drv |-> bsy_drv);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    selected |=> !selected);

  assert_rst_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !req_drv && !selected && (bus_rst || st == IDLE));
endmodule

// File: tb/sel_responder_test.sv
module sel_responder_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_bsy = 0, bus_io = 0, bus_rst = 0, bus_par = 0;
  logic [7:0] bus_data = 0;
  logic [2:0] own_id = 3'd5;
  logic bsy_drv, req_drv, init_id_ok, selected;
  logic [2:0] init_id;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sel_responder #(.SETTLE_CYC(4), .ABORT_CYC(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_bsy(bus_bsy), .bus_io(bus_io),
    .bus_rst(bus_rst), .bus_data(bus_data), .bus_par(bus_par), .own_id(own_id),
    .bsy_drv(bsy_drv), .req_drv(req_drv), .init_id(init_id), .init_id_ok(init_id_ok),
    .selected(selected));

  // {data, par, bsy, io, expect_claim, expect_id, expect_valid}; own_id = 5
  localparam logic [15:0] VEC [9] = '{
    {8'h21, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1},  // R2 R10
    {8'hA0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1},  // R10 highest
    {8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0},  // R10 no other bit
    {8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},  // R3
    {8'h25, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},  // R4
    {8'h21, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},  // R5 bsy
    {8'h21, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0},  // R5 io
    {8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},  // R5 own bit
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}   // R3 zero byte
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic [7:0] d, input logic p, input logic b, input logic i);
    bus_sel = s; bus_data = d; bus_par = p; bus_bsy = b; bus_io = i;
  endtask

  task automatic clear();
    bus_rst = 1; drive(0, 0, 0, 0, 0); step(1);
    bus_rst = 0; step(1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk({bsy_drv, req_drv, selected, init_id, init_id_ok} == 0, "R1 reset",
        {bsy_drv, req_drv, selected, init_id, init_id_ok}, 0);

    for (int k = 0; k < 9; k++) begin
      logic [15:0] v = VEC[k];
      clear();
      drive(1, v[15:8], v[7], v[6], v[5]);
      step(5);
      chk(bsy_drv == 0, "R2 early", bsy_drv, 0);
      step(1);
      chk(bsy_drv == v[4], "R2 R3 R4 R5 claim", bsy_drv, v[4]);
      if (v[4]) begin
        chk(init_id == v[3:1] && init_id_ok == v[0], "R10 id", {init_id, init_id_ok}, v[3:0]);
        step(3);
        chk(req_drv == 0 && bsy_drv == 1, "R9 hold", {bsy_drv, req_drv}, 2);
        bus_sel = 0;
        step(1);
        chk(req_drv == 1 && selected == 1, "R9 req", {req_drv, selected}, 3);
        step(1);
        chk(req_drv == 1 && selected == 0, "R9 pulse", {req_drv, selected}, 2);
      end
    end

    // R6: changing the byte mid-settle restarts the count
    clear();
    drive(1, 8'h21, 1, 0, 0);
    step(3);
    drive(1, 8'hA0, 1, 0, 0);
    step(5);
    chk(bsy_drv == 0, "R6 restart", bsy_drv, 0);
    step(1);
    chk(bsy_drv == 1 && init_id == 3'd7, "R6 claim", {bsy_drv, init_id}, 4'hF);

    // R7/R8: selection lost in the re-check cycle
    clear();
    drive(1, 8'h21, 1, 0, 0);
    step(5);
    bus_io = 1;
    step(1);
    chk(bsy_drv == 0, "R7 recheck", bsy_drv, 0);
    step(3);
    chk(bsy_drv == 0, "R7 idle", bsy_drv, 0);

    // R11: bus reset drops busy in the same cycle
    clear();
    drive(1, 8'h21, 1, 0, 0);
    step(6);
    chk(bsy_drv == 1, "R8 claim", bsy_drv, 1);
    bus_rst = 1;
    #1;
    chk(bsy_drv == 0, "R11 immediate", bsy_drv, 0);

    // R11: reset on the same edge as SEL release
    clear();
    drive(1, 8'h21, 1, 0, 0);
    step(6);
    bus_sel = 0; bus_rst = 1;
    step(1);
    chk(req_drv == 0 && selected == 0, "R11 coincident", {req_drv, selected}, 0);
    bus_rst = 0;
    step(2);
    chk(req_drv == 0 && bsy_drv == 0 && selected == 0, "R11 idle", {bsy_drv, req_drv, selected}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule